// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes a DDR3 device from power-up reset to an idle state that a memory controller can use. It drives a single-phase command port: chip select, row strobe, column strobe, write enable, bank and address, plus clock enable, on-die termination and the device reset line. A one-cycle start pulse begins the sequence. The block first releases the device reset with termination enabled and clock enable low. After a programmable wait it raises clock enable, and after a second wait it loads the four mode registers in the order DDR3 requires. It then issues a long ZQ calibration.

Every wait is a parameter in clock cycles. The timing in the ports is therefore set when the block is built, not at run time. When the final wait ends, the block raises `done_o`. It also hands the pins to the downstream controller by raising `sel_o` and releasing its own clock-enable, termination and reset drives. Refresh, training, delay-line adjustment and the data path are not part of this block.

Top module: `ddr3_init_seq`

## Requirements
- R1: While reset is asserted and after it is released with no start, the outputs are `mem_rst_n_o`=0, `cke_o`=0, `odt_o`=0, `sel_o`=0, `done_o`=0, with a NOP on the command pins (`cs_n_o`, `ras_n_o`, `cas_n_o`, `we_n_o` all 1) and bank and address at zero. Reset forces these values at once, without waiting for a clock edge.
- R2: A high `start_i` in the idle state begins the sequence. Every registered output changes one cycle after the clock edge that samples the start. Holding `start_i` high during the sequence does not change it. A start after completion does not change it either.
- R3: The first phase lasts T_RST cycles. In it `mem_rst_n_o`=1, `odt_o`=1, `cke_o`=0, and the pins carry a NOP with bank and address at 0.
- R4: The second phase lasts T_CKE cycles. In it `cke_o` is also 1, and the pins still carry a NOP.
- R5: Four mode-register loads follow, in this order: bank 2 with address 0x200, bank 3 with 0x000, bank 1 with 0x006, and bank 0 with 0x920. Each load drives all four command strobes low for exactly one cycle. Each pair of loads is separated by T_MRD cycles of NOP.
- R6: After the last load, T_MOD NOP cycles follow. Then ZQ calibration is issued for one cycle, with `cs_n_o`=0, `we_n_o`=0, `ras_n_o`=1, `cas_n_o`=1, address 0x400 and bank 0.
- R7: After the calibration command, T_ZQ NOP cycles follow. On the next cycle `done_o` and `sel_o` rise together, and `cke_o`, `odt_o` and `mem_rst_n_o` go to 0.
- R8: Once high, `done_o` and `sel_o` stay high until reset.
- R9: From the start of the second phase to the end of the calibration wait, `cke_o`, `odt_o` and `mem_rst_n_o` are all 1. No command is issued while `cke_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start request, sampled only in idle |
| cke_o | output | 1 | Clock enable to the device |
| odt_o | output | 1 | On-die termination enable |
| mem_rst_n_o | output | 1 | Device reset, active low |
| sel_o | output | 1 | High when the downstream controller owns the pins |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| bank_o | output | BANK_W | Bank address |
| addr_o | output | ADDR_W | Row/mode address |
| done_o | output | 1 | Sequence complete |

## Verification
A wrong step register or a wrong wait count appears at the pins as a shifted command cycle, a wrong bank or address on a load, or a change in control level at the wrong time. The error shows within one cycle of the point where the sequence leaves its schedule. The bench therefore compares every pin on every cycle of the whole sequence against a schedule it builds from the wait parameters. Faults in ownership show as `cke_o` or `mem_rst_n_o` out of step with the phase, or as a `done_o` that falls again. These also show in the cycle they occur.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_RST  = 4'd1,
    ST_CKE  = 4'd2,
    ST_MR2  = 4'd3,
    ST_G2   = 4'd4,
    ST_MR3  = 4'd5,
    ST_G3   = 4'd6,
    ST_MR1  = 4'd7,
    ST_G1   = 4'd8,
    ST_MR0  = 4'd9,
    ST_WMOD = 4'd10,
    ST_ZQ   = 4'd11,
    ST_WZQ  = 4'd12,
    ST_DONE = 4'd13
  } step_t;

  // control word bit positions (active-high word)
  localparam int CTL_SEL  = 0;
  localparam int CTL_CKE  = 1;
  localparam int CTL_ODT  = 2;
  localparam int CTL_RSTN = 3;

  // command strobe bit positions (active-high, inverted at the pins)
  localparam int CMD_CS  = 0;
  localparam int CMD_WE  = 1;
  localparam int CMD_CAS = 2;
  localparam int CMD_RAS = 3;

  localparam logic [3:0] CMD_NOP  = 4'b0000;
  localparam logic [3:0] CMD_MRS  = 4'b1111;
  localparam logic [3:0] CMD_ZQCL = 4'b0011;

  localparam logic [15:0] MR0_VAL = 16'h0920;
  localparam logic [15:0] MR1_VAL = 16'h0006;
  localparam logic [15:0] MR2_VAL = 16'h0200;
  localparam logic [15:0] MR3_VAL = 16'h0000;
  localparam logic [15:0] ZQ_ADDR = 16'h0400;

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign zero_o = (cnt_q == '0);
  assign cnt_en = load_i || !zero_o;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)       cnt_d = load_val_i;
    else if (!zero_o) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // an idle counter stays idle until reloaded (feeds the wait lengths of R3-R7)
  p_timer_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/ddr3_init_fsm.sv
module ddr3_init_fsm
  import ddr3_init_pkg::*;
#(
  parameter int T_RST = 50000,
  parameter int T_CKE = 10000,
  parameter int T_MRD = 4,
  parameter int T_MOD = 200,
  parameter int T_ZQ  = 200,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tmr_zero_i,
  output step_t            step_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o
);

  step_t st_q;
  step_t st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i)    st_d = ST_RST;
      ST_RST:  if (tmr_zero_i) st_d = ST_CKE;
      ST_CKE:  if (tmr_zero_i) st_d = ST_MR2;
      ST_MR2:                  st_d = ST_G2;
      ST_G2:   if (tmr_zero_i) st_d = ST_MR3;
      ST_MR3:                  st_d = ST_G3;
      ST_G3:   if (tmr_zero_i) st_d = ST_MR1;
      ST_MR1:                  st_d = ST_G1;
      ST_G1:   if (tmr_zero_i) st_d = ST_MR0;
      ST_MR0:                  st_d = ST_WMOD;
      ST_WMOD: if (tmr_zero_i) st_d = ST_ZQ;
      ST_ZQ:                   st_d = ST_WZQ;
      ST_WZQ:  if (tmr_zero_i) st_d = ST_DONE;
      ST_DONE:                 st_d = ST_DONE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  // load the wait counter on entry to a timed step; the step lasts exactly T cycles
  always_comb begin
    tmr_val_o = '0;
    unique case (st_d)
      ST_RST:              tmr_val_o = CNT_W'(T_RST - 1);
      ST_CKE:              tmr_val_o = CNT_W'(T_CKE - 1);
      ST_G2, ST_G3, ST_G1: tmr_val_o = CNT_W'(T_MRD - 1);
      ST_WMOD:             tmr_val_o = CNT_W'(T_MOD - 1);
      ST_WZQ:              tmr_val_o = CNT_W'(T_ZQ - 1);
      default:             tmr_val_o = '0;
    endcase
  end

  assign tmr_load_o = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign step_o = st_q;

  logic in_wait;
  assign in_wait = (st_q == ST_RST) || (st_q == ST_CKE) || (st_q == ST_G2) ||
                   (st_q == ST_G3)  || (st_q == ST_G1)  || (st_q == ST_WMOD) ||
                   (st_q == ST_WZQ);

  p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_i) |=> (st_q == ST_RST));

  p_wait_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !tmr_zero_i) |=> (st_q == $past(st_q)));

  p_done_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |=> (st_q == ST_DONE));

endmodule

// File: rtl/ddr3_init_drive.sv
module ddr3_init_drive
  import ddr3_init_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  step_t              step_i,
  output logic [3:0]         ctl_o,
  output logic [3:0]         cmd_o,
  output logic [BANK_W-1:0]  bank_o,
  output logic [ADDR_W-1:0]  addr_o
);

  localparam logic [3:0] CTL_OFF  = 4'b0000;
  localparam logic [3:0] CTL_REL  = (4'b1 << CTL_RSTN) | (4'b1 << CTL_ODT);
  localparam logic [3:0] CTL_OWN  = CTL_REL | (4'b1 << CTL_CKE);
  localparam logic [3:0] CTL_HAND = (4'b1 << CTL_SEL);

  always_comb begin
    ctl_o  = CTL_OWN;
    cmd_o  = CMD_NOP;
    bank_o = '0;
    addr_o = '0;
    unique case (step_i)
      ST_IDLE: ctl_o = CTL_OFF;
      ST_RST:  ctl_o = CTL_REL;
      ST_MR2: begin
        cmd_o  = CMD_MRS;
        bank_o = BANK_W'(2);
        addr_o = ADDR_W'(MR2_VAL);
      end
      ST_MR3: begin
        cmd_o  = CMD_MRS;
        bank_o = BANK_W'(3);
        addr_o = ADDR_W'(MR3_VAL);
      end
      ST_MR1: begin
        cmd_o  = CMD_MRS;
        bank_o = BANK_W'(1);
        addr_o = ADDR_W'(MR1_VAL);
      end
      ST_MR0: begin
        cmd_o  = CMD_MRS;
        bank_o = BANK_W'(0);
        addr_o = ADDR_W'(MR0_VAL);
      end
      ST_ZQ: begin
        cmd_o  = CMD_ZQCL;
        addr_o = ADDR_W'(ZQ_ADDR);
      end
      ST_DONE: ctl_o = CTL_HAND;
      default: ctl_o = CTL_OWN;
    endcase
  end

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int T_RST  = 50000,
  parameter int T_CKE  = 10000,
  parameter int T_MRD  = 4,
  parameter int T_MOD  = 200,
  parameter int T_ZQ   = 200,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              cke_o,
  output logic              odt_o,
  output logic              mem_rst_n_o,
  output logic              sel_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  localparam int T_A   = (T_RST > T_CKE) ? T_RST : T_CKE;
  localparam int T_B   = (T_MOD > T_ZQ)  ? T_MOD : T_ZQ;
  localparam int T_C   = (T_A > T_B) ? T_A : T_B;
  localparam int T_MAX = (T_C > T_MRD) ? T_C : T_MRD;
  localparam int CNT_W = (T_MAX > 2) ? $clog2(T_MAX) : 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  step_t             step;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic [3:0]        ctl_c;
  logic [3:0]        cmd_c;
  logic [BANK_W-1:0] bank_c;
  logic [ADDR_W-1:0] addr_c;

  ddr3_init_fsm #(
    .T_RST(T_RST), .T_CKE(T_CKE), .T_MRD(T_MRD),
    .T_MOD(T_MOD), .T_ZQ(T_ZQ), .CNT_W(CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .tmr_zero_i (tmr_zero),
    .step_o     (step),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val)
  );

  ddr3_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  ddr3_init_drive #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_drive (
    .step_i (step),
    .ctl_o  (ctl_c),
    .cmd_o  (cmd_c),
    .bank_o (bank_c),
    .addr_o (addr_c)
  );

  // registered pins; reset values are the idle state (R1)
  logic [3:0]        ctl_q;
  logic [3:0]        cmd_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic              done_d;

  assign done_d = (step == ST_DONE);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctl_q  <= '0;
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_c;
      cmd_q  <= cmd_c;
      bank_q <= bank_c;
      addr_q <= addr_c;
      done_q <= done_d;
    end
  end

  assign sel_o       = ctl_q[CTL_SEL];
  assign cke_o       = ctl_q[CTL_CKE];
  assign odt_o       = ctl_q[CTL_ODT];
  assign mem_rst_n_o = ctl_q[CTL_RSTN];
  assign cs_n_o      = ~cmd_q[CMD_CS];
  assign we_n_o      = ~cmd_q[CMD_WE];
  assign cas_n_o     = ~cmd_q[CMD_CAS];
  assign ras_n_o     = ~cmd_q[CMD_RAS];
  assign bank_o      = bank_q;
  assign addr_o      = addr_q;
  assign done_o      = done_q;

  logic mrs_pins;
  assign mrs_pins = !cs_n_o && !ras_n_o && !cas_n_o && !we_n_o;

  p_mrs_single_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    mrs_pins |=> !mrs_pins);

  p_cke_under_rst_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    cke_o |-> mem_rst_n_o);

  p_cmd_needs_cke_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cs_n_o |-> cke_o);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> (done_o && sel_o));

  p_handoff_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(done_o) |-> (sel_o && !cke_o && !odt_o && !mem_rst_n_o && cs_n_o));

endmodule

// File: tb/ddr3_init_seq_tb.sv
module ddr3_init_seq_tb;

  localparam int LR = 5;
  localparam int LC = 3;
  localparam int LM = 2;
  localparam int LD = 4;
  localparam int LZ = 3;
  localparam int AW = 14;
  localparam int BW = 3;
  localparam int P0   = LR + LC + 1;               // first mode load
  localparam int PM0  = P0 + 3 * (1 + LM);         // last mode load
  localparam int PZ   = PM0 + LD + 1;              // calibration command
  localparam int LAST = PZ + LZ;                   // last owned cycle
  localparam int VW   = 9 + BW + AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cke, odt, mrstn, sel, csn, rasn, casn, wen, done;
  logic [BW-1:0] bank;
  logic [AW-1:0] addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  ddr3_init_seq #(
    .T_RST(LR), .T_CKE(LC), .T_MRD(LM), .T_MOD(LD), .T_ZQ(LZ),
    .ADDR_W(AW), .BANK_W(BW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .cke_o(cke), .odt_o(odt), .mem_rst_n_o(mrstn), .sel_o(sel),
    .cs_n_o(csn), .ras_n_o(rasn), .cas_n_o(casn), .we_n_o(wen),
    .bank_o(bank), .addr_o(addr), .done_o(done)
  );

  function automatic logic [VW-1:0] pack(
      logic d, logic s, logic k, logic o, logic r,
      logic c, logic ra, logic ca, logic w, int b, int a);
    return {d, s, k, o, r, c, ra, ca, w, BW'(b), AW'(a)};
  endfunction

  function automatic logic [VW-1:0] idle_vec();
    return pack(0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0);
  endfunction

  // expected pins j cycles after the first registered output of a run
  function automatic logic [VW-1:0] exp_vec(int j);
    int bk [4] = '{2, 3, 1, 0};
    int av [4] = '{32'h200, 32'h000, 32'h006, 32'h920};
    if (j <= 0) return idle_vec();
    if (j <= LR) return pack(0, 0, 0, 1, 1, 1, 1, 1, 1, 0, 0);
    if (j <= LR + LC) return pack(0, 0, 1, 1, 1, 1, 1, 1, 1, 0, 0);
    if (j <= LAST) begin
      for (int k = 0; k < 4; k++)
        if (j == P0 + k * (1 + LM)) return pack(0, 0, 1, 1, 1, 0, 0, 0, 0, bk[k], av[k]);
      if (j == PZ) return pack(0, 0, 1, 1, 1, 0, 1, 1, 0, 0, 32'h400);
      return pack(0, 0, 1, 1, 1, 1, 1, 1, 1, 0, 0);
    end
    return pack(1, 1, 0, 0, 0, 1, 1, 1, 1, 0, 0);
  endfunction

  function automatic string req_of(int j);
    if (j <= 0) return "R2";
    if (j <= LR) return "R3";
    if (j <= LR + LC) return "R4";
    if (j <= PM0) return "R5";
    if (j <= PZ) return "R6";
    if (j <= LAST) return "R9";
    return "R7";
  endfunction

  function automatic logic [VW-1:0] actual();
    return {done, sel, cke, odt, mrstn, csn, rasn, casn, wen, bank, addr};
  endfunction

  task automatic chk(logic [VW-1:0] exp, string req, int idx);
    checks++;
    if (actual() !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, idx, actual(), exp);
    end
  endtask

  task automatic sweep(bit hold);
    start = 1'b1;
    @(negedge clk);
    if (!hold) start = 1'b0;
    for (int i = 1; i <= LAST + 5; i++) begin
      chk(exp_vec(i - 1), req_of(i - 1), i);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk(idle_vec(), "R1", 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state and idle with no start
    do_reset();
    for (int i = 0; i < 4; i++) begin
      chk(idle_vec(), "R1", i);
      @(negedge clk);
    end
    // full schedule with a one-cycle start (R3 R4 R5 R6 R7 R9)
    sweep(1'b0);
    // R8 and R2: start after completion is ignored, done stays
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      chk(exp_vec(LAST + 1), "R8", i);
      @(negedge clk);
    end
    // R2: start held high for the whole run gives the same schedule
    do_reset();
    sweep(1'b1);
    // R1: reset in mid-run returns the pins to idle at once, then a clean rerun
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (LR + LC + 2) @(negedge clk);
    do_reset();
    for (int i = 0; i < 3; i++) begin
      chk(idle_vec(), "R1", i);
      @(negedge clk);
    end
    sweep(1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule